// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block turns one externally supplied word address into the four addresses of a short burst. A start strobe samples the address pins at a rising clock edge. The following beats come from an internal two-bit beat counter and do not use the pins again. The counter moves forward one beat at each rising edge where the advance input is held low. The beats can run in one of two orders, and an order-select input chooses between them. Linear order adds the beat count to the loaded low bits. Interleaved order XORs the beat count with the loaded low bits.

There are two start strobes. The processor-side strobe is obeyed only while the primary chip select is asserted. The controller-side strobe is obeyed whatever the chip select is doing. A start always takes precedence over an advance. A sleep input, sampled at the clock, freezes the sequencer as long as it is high. The output drives the word address of a memory array and has no data path of its own.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and just after it is released, `wordAddr` is 0.
- R2: With `sleep` low, `ctrlStrobeN` low at a rising edge loads `addrIn`. `wordAddr` then equals that address, whatever the level of `chipSelN`.
- R3: With `sleep` low and `chipSelN` low, `procStrobeN` low at a rising edge loads `addrIn` into `wordAddr`.
- R4: `procStrobeN` low while `chipSelN` is high has no effect. `wordAddr` keeps its value when no advance is requested.
- R5: With `orderSel` = 0 (linear), each advance makes bits [1:0] equal to the loaded bits [1:0] plus the number of advances, modulo 4. Bits [17:2] stay at the loaded value.
- R6: With `orderSel` = 1 (interleaved), bits [1:0] equal the loaded bits [1:0] XOR the number of advances modulo 4. Bits [17:2] stay at the loaded value.
- R7: A rising edge with `advanceN` high and no honoured strobe leaves `wordAddr` unchanged.
- R8: A strobe that is honoured at the same edge as an advance reloads `addrIn` and clears the beat count. The advance is dropped.
- R9: While `sleep` is high at a rising edge, `wordAddr` and the beat count hold, even if strobes and advance are asserted.
- R10: After four advances the burst wraps back to the loaded address, in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | 18 | External word address |
| procStrobeN | input | 1 | Processor-side burst start, active low, gated by chip select |
| ctrlStrobeN | input | 1 | Controller-side burst start, active low, ungated |
| chipSelN | input | 1 | Primary chip select, active low |
| advanceN | input | 1 | Beat advance request, active low |
| orderSel | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Hold request, active high, sampled at the clock |
| wordAddr | output | 18 | Current burst word address |

## Verification
The hold and step properties assume that `orderSel` is a static strap. The output uses that input directly, so a change in the middle of a burst would move the address with no clock edge. For that reason each such property excuses any cycle in which `orderSel` changed. The stimulus changes `orderSel` only between bursts, always before the strobe that starts a new burst. All inputs are changed two nanoseconds after a rising edge, so every sampled level is settled before the next edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Command from the control to the datapath for one clock edge
  typedef struct packed {
    logic load;   // capture the pins, restart the beat count
    logic step;   // move to the next beat
  } seqCmd_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burstOrder_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic    procStrobeN,
  input  logic    ctrlStrobeN,
  input  logic    chipSelN,
  input  logic    advanceN,
  input  logic    sleep,
  output seqCmd_t cmd
);

  logic procStart;
  logic ctrlStart;
  logic anyStart;

  // The processor strobe counts only while the chip is selected
  assign procStart = !procStrobeN && !chipSelN;
  assign ctrlStart = !ctrlStrobeN;
  assign anyStart  = procStart || ctrlStart;

  always_comb begin
    cmd = '0;
    if (!sleep) begin
      cmd.load = anyStart;
      cmd.step = !anyStart && !advanceN;
    end
  end

endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              orderSel,
  input  seqCmd_t           cmd,
  output logic [ADDR_W-1:0] wordAddr
);

  localparam int UPPER_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  beatQ;
  logic [CNT_W-1:0]  linLow;
  logic [CNT_W-1:0]  intLow;
  logic [CNT_W-1:0]  lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      beatQ <= '0;
    end else if (cmd.load) begin
      baseQ <= addrIn;
      beatQ <= '0;
    end else if (cmd.step) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  // Linear order: the carry stays inside the low field, so it wraps
  assign linLow = baseQ[CNT_W-1:0] + beatQ;

  // Interleaved order: each low bit flips with the matching count bit
  for (genvar b = 0; b < CNT_W; b++) begin : g_xorBit
    assign intLow[b] = baseQ[b] ^ beatQ[b];
  end

  assign lowBits  = (burstOrder_e'(orderSel) == ORDER_INTERLEAVE) ? intLow : linLow;
  assign wordAddr = {baseQ[ADDR_W-1:CNT_W], lowBits};

  // R8: any honoured start clears the beat count, whatever advance did
  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (beatQ == '0));

  // R5/R6: the upper field moves only on a load
  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> (wordAddr[ADDR_W-1:CNT_W] == $past(wordAddr[ADDR_W-1:CNT_W])));

  // R7: no command means the beat count holds
  p_idle_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.step) |=> $stable(beatQ));

  if (UPPER_W < 1) begin : g_badWidth
    initial $error("address must be wider than the beat counter");
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              chipSelN,
  input  logic              advanceN,
  input  logic              orderSel,
  input  logic              sleep,
  output logic [ADDR_W-1:0] wordAddr
);

  seqCmd_t cmd;

  burst_ctrl u_ctrl (
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .chipSelN    (chipSelN),
    .advanceN    (advanceN),
    .sleep       (sleep),
    .cmd         (cmd)
  );

  burst_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .addrIn   (addrIn),
    .orderSel (orderSel),
    .cmd      (cmd),
    .wordAddr (wordAddr)
  );

  // R2: controller strobe loads the pins regardless of chip select
  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !ctrlStrobeN) |=> (wordAddr == $past(addrIn)));

  // R3: gated processor strobe loads the pins
  p_proc_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !procStrobeN && !chipSelN) |=> (wordAddr == $past(addrIn)));

  // R4: deselected processor strobe with no advance leaves the address alone
  p_proc_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && ctrlStrobeN && chipSelN && advanceN)
      |=> ($stable(wordAddr) || !$stable(orderSel)));

  // R9: sleep freezes the address
  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(wordAddr) || !$stable(orderSel)));

  // R5: a linear step adds one to the low field
  p_lin_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && ctrlStrobeN && (procStrobeN || chipSelN) && !advanceN && !orderSel)
      |=> (orderSel ||
           (wordAddr[CNT_W-1:0] == CNT_W'($past(wordAddr[CNT_W-1:0]) + 1'b1))));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addrIn;
  logic          procStrobeN, ctrlStrobeN, chipSelN, advanceN, orderSel, sleep;
  logic [AW-1:0] wordAddr;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .chipSelN(chipSelN),
    .advanceN(advanceN), .orderSel(orderSel), .sleep(sleep), .wordAddr(wordAddr)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idleInputs();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; chipSelN = 1'b1;
    advanceN = 1'b1; sleep = 1'b0;
  endtask

  function automatic logic [AW-1:0] beatAddr(input logic [AW-1:0] base, input int k, input logic ord);
    logic [1:0] kk = 2'(k);
    return ord ? {base[AW-1:2], base[1:0] ^ kk} : {base[AW-1:2], 2'(base[1:0] + kk)};
  endfunction

  task automatic startCtrl(input logic [AW-1:0] a);
    addrIn = a; ctrlStrobeN = 1'b0;
    tick();
    ctrlStrobeN = 1'b1;
  endtask

  task automatic t_reset();
    rstN = 1'b0; idleInputs(); orderSel = 1'b0; addrIn = 18'h2AAAA;
    tick(); tick();
    check("R1 in reset", wordAddr, '0);
    rstN = 1'b1;
    tick();
    check("R1 after release", wordAddr, '0);
  endtask

  task automatic t_ctrlLoad();
    chipSelN = 1'b1;
    startCtrl(18'h12345);
    check("R2 ctrl load deselected", wordAddr, 18'h12345);
    chipSelN = 1'b0;
    startCtrl(18'h3FFFE);
    check("R2 ctrl load selected", wordAddr, 18'h3FFFE);
    chipSelN = 1'b1;
  endtask

  task automatic t_procLoad();
    chipSelN = 1'b0; addrIn = 18'h0ABC1; procStrobeN = 1'b0;
    tick();
    procStrobeN = 1'b1;
    check("R3 proc load", wordAddr, 18'h0ABC1);
    chipSelN = 1'b1;
  endtask

  task automatic t_procGated();
    startCtrl(18'h01110);
    chipSelN = 1'b1; addrIn = 18'h3C3C3; procStrobeN = 1'b0;
    tick(); tick();
    procStrobeN = 1'b1;
    check("R4 proc ignored", wordAddr, 18'h01110);
  endtask

  task automatic t_burst(input string req, input logic ord, input logic [AW-1:0] base);
    orderSel = ord;
    startCtrl(base);
    for (int k = 1; k <= 4; k++) begin
      advanceN = 1'b0;
      tick();
      advanceN = 1'b1;
      if (k < 4) check(req, wordAddr, beatAddr(base, k, ord));
      else       check("R10 wrap", wordAddr, base);
    end
  endtask

  task automatic t_hold();
    orderSel = 1'b0;
    startCtrl(18'h20001);
    advanceN = 1'b0; tick(); advanceN = 1'b1;
    tick(); tick();
    check("R7 no advance holds", wordAddr, 18'h20002);
    advanceN = 1'b0; tick(); advanceN = 1'b1;
    check("R7 resume step", wordAddr, 18'h20003);
  endtask

  task automatic t_priority();
    orderSel = 1'b1;
    startCtrl(18'h15552);
    advanceN = 1'b0; tick();
    check("R8 pre step", wordAddr, 18'h15553);
    addrIn = 18'h0F0F1; ctrlStrobeN = 1'b0;
    tick();
    ctrlStrobeN = 1'b1;
    check("R8 strobe beats advance", wordAddr, 18'h0F0F1);
    tick();
    advanceN = 1'b1;
    check("R8 count restarted", wordAddr, 18'h0F0F0);
  endtask

  task automatic t_sleep();
    orderSel = 1'b0;
    startCtrl(18'h00403);
    sleep = 1'b1; advanceN = 1'b0; ctrlStrobeN = 1'b0; addrIn = 18'h3FFFF;
    tick(); tick();
    check("R9 sleep holds", wordAddr, 18'h00403);
    ctrlStrobeN = 1'b1;
    sleep = 1'b0;
    tick();
    advanceN = 1'b1;
    check("R9 wake step", wordAddr, 18'h00400);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ctrlLoad();
        t_procLoad();
        t_procGated();
        t_burst("R5 linear", 1'b0, 18'h2C7A1);
        t_burst("R6 interleave", 1'b1, 18'h2C7A2);
        t_burst("R6 interleave base3", 1'b1, 18'h00003);
        t_hold();
        t_priority();
        t_sleep();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule